// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank

This block holds a small bank of clock-enable dividers that share one clock. Each divider counts the enable strobes on `in_en` and sends out one strobe per period. The period length comes from a ratio field in a single shared control word. The output is a one-cycle enable that downstream logic qualifies its flops with. No derived clock is produced.

Software writes the control word with a masked write. Each ratio field has its own write-enable bit, 16 places above the field's lowest bit. A field changes only when its write-enable bit is set in the same write, so one write can retarget any subset of the dividers. A new ratio does not take effect at once. It is held as pending, and the divider's busy bit stays high until the current divided period ends. At that point the pending ratio becomes active and busy drops. Software waits for busy to be low before it writes and again after it writes. The busy bits of all dividers appear together as one status vector.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every active ratio is 0 and every busy bit is 0, so each `in_en` strobe is passed straight to every `div_en_o` bit.
- R2: With active ratio v, divider i drives `div_en_o[i]` high on every (v+1)-th cycle that has `in_en` high, and never on a cycle with `in_en` low. The counter restarts when the period ends.
- R3: A write with `wr_en` high, bit (i*FIELD_W+16) set, and a field value in bits [i*FIELD_W +: FIELD_W] that differs from the active ratio sets `busy_o[i]` on the next cycle. The active ratio does not change before the period end.
- R4: If bit (i*FIELD_W+16) of the write data is 0, divider i ignores the write. Its ratio readback and busy bit are unchanged, whatever the field bits hold.
- R5: On the cycle whose `in_en` strobe ends a period while busy, the pending ratio becomes active and busy clears on that same edge. The new ratio counts from a fresh period.
- R6: A masked write to a divider that is already busy replaces its pending ratio and leaves busy set. The last value written is the one that loads.
- R7: A masked write of the value that is already active, made while the divider is idle, leaves busy at 0.
- R8: The dividers work independently. `ratio_o[i*FIELD_W +: FIELD_W]` reads back the active ratio of divider i, and `busy_o[i]` is its busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 1 | Input clock-enable strobe that is divided |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Write data: ratio fields in the low half, per-field write enables 16 places higher |
| div_en_o | output | NUM_DIV | Divided enable strobe, one bit per divider |
| busy_o | output | NUM_DIV | Status vector: bit i high while a ratio update of divider i is pending |
| ratio_o | output | NUM_DIV*FIELD_W | Readback of the active ratios |

## Verification
The assertions assume that `wr_en` and `in_en` are well-defined levels that are sampled once per clock. They also assume that `NUM_DIV*FIELD_W` fits in the 16 low bits.

The properties on busy clearing and on ratio stability exclude the cycle where a write lands on a period end. The stimulus never drives `wr_en` and `in_en` high in the same cycle, so each write and each counted strobe can be checked on its own. Reset is applied once at the start and again in mid-run, while an update is pending.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned CTRL_W         = 32;
  localparam int unsigned WEN_OFS        = 16;
  localparam int unsigned MAX_FIELD_BITS = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } upd_state_e;
endpackage

// File: rtl/cdiv_wr_decode.sv
module cdiv_wr_decode
  import cdiv_pkg::*;
#(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned SHIFT   = 0
) (
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  output logic               hit,
  output logic [FIELD_W-1:0] value
);
  localparam int unsigned WEN_BIT = SHIFT + WEN_OFS;

  always_comb begin
    hit   = wr_en && wr_data[WEN_BIT];
    value = wr_data[SHIFT +: FIELD_W];
  end
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
  import cdiv_pkg::*;
#(
  parameter int unsigned FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_en,
  input  logic               wr_hit,
  input  logic [FIELD_W-1:0] wr_val,
  output logic               div_en,
  output logic               busy,
  output logic [FIELD_W-1:0] ratio
);
  logic [FIELD_W-1:0] act_q, pend_q, cnt_q, act_nx;
  upd_state_e         st_q;
  logic               period_end, take;

  always_comb begin
    period_end = in_en && (cnt_q == act_q);
    act_nx     = (period_end && st_q == ST_PEND) ? pend_q : act_q;
    take       = wr_hit && ((wr_val != act_nx) || (st_q == ST_PEND && !period_end));
    div_en     = period_end;
    busy       = (st_q == ST_PEND);
    ratio      = act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      st_q   <= ST_IDLE;
    end else begin
      act_q <= act_nx;
      if (in_en) cnt_q <= period_end ? '0 : cnt_q + 1'b1;
      if (take) begin
        pend_q <= wr_val;
        st_q   <= ST_PEND;
      end else if (period_end) begin
        st_q   <= ST_IDLE;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q); // R2
  AST_CHANGE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !period_end && wr_val != act_q) |=> busy); // R3
  AST_RATIO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(period_end && busy) |=> $stable(act_q)); // R3
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_hit) |=> !busy); // R4
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && busy && !wr_hit) |=> !busy); // R5
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && busy) |=> (act_q == $past(pend_q))); // R5
  AST_REPLACE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_hit && !period_end) |=> (busy && pend_q == $past(wr_val))); // R6
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import cdiv_pkg::*;
#(
  parameter int unsigned NUM_DIV = 2,
  parameter int unsigned FIELD_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_en,
  input  logic                         wr_en,
  input  logic [31:0]                  wr_data,
  output logic [NUM_DIV-1:0]           div_en_o,
  output logic [NUM_DIV-1:0]           busy_o,
  output logic [NUM_DIV*FIELD_W-1:0]   ratio_o
);
  localparam int unsigned FIELD_SPAN = NUM_DIV * FIELD_W;

  if (FIELD_SPAN > MAX_FIELD_BITS) begin : g_bad_cfg
    $error("ratio fields exceed the low half of the control word");
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    logic               hit;
    logic [FIELD_W-1:0] val;

    cdiv_wr_decode #(.FIELD_W(FIELD_W), .SHIFT(i * FIELD_W)) u_dec (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .hit     (hit),
      .value   (val)
    );

    cdiv_core #(.FIELD_W(FIELD_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_en  (in_en),
      .wr_hit (hit),
      .wr_val (val),
      .div_en (div_en_o[i]),
      .busy   (busy_o[i]),
      .ratio  (ratio_o[i*FIELD_W +: FIELD_W])
    );
  end
endmodule

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  div_en_o, busy_o;
  logic [7:0]  ratio_o;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  clkdiv_bank #(.NUM_DIV(2), .FIELD_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .wr_en(wr_en), .wr_data(wr_data),
    .div_en_o(div_en_o), .busy_o(busy_o), .ratio_o(ratio_o)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] data;
    logic        en;
    logic [1:0]  pulse;
    logic [1:0]  busy;
    logic [7:0]  ratio;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 1'b1, 2'b11, 2'b00, 8'h00, 4'd1}, // R1 pass-through
    {1'b1, 32'h0001_0002, 1'b0, 2'b00, 2'b01, 8'h00, 4'd3}, // R3 d0 <- 2
    {1'b0, 32'h0000_0000, 1'b1, 2'b11, 2'b00, 8'h02, 4'd5}, // R5 load
    {1'b0, 32'h0000_0000, 1'b1, 2'b10, 2'b00, 8'h02, 4'd2}, // R2
    {1'b0, 32'h0000_0000, 1'b1, 2'b10, 2'b00, 8'h02, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b11, 2'b00, 8'h02, 4'd2},
    {1'b1, 32'h0000_0050, 1'b0, 2'b00, 2'b00, 8'h02, 4'd4}, // R4 masked off
    {1'b1, 32'h0010_0030, 1'b0, 2'b00, 2'b10, 8'h02, 4'd8}, // R8 only d1
    {1'b1, 32'h0010_0070, 1'b0, 2'b00, 2'b10, 8'h02, 4'd6}, // R6 replace
    {1'b0, 32'h0000_0000, 1'b1, 2'b10, 2'b00, 8'h72, 4'd6},
    {1'b1, 32'h0001_0002, 1'b0, 2'b00, 2'b00, 8'h72, 4'd7}, // R7 same value
    {1'b0, 32'h0000_0000, 1'b1, 2'b00, 2'b00, 8'h72, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b00, 8'h72, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b00, 2'b00, 8'h72, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b00, 2'b00, 8'h72, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b00, 8'h72, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b00, 2'b00, 8'h72, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b00, 2'b00, 8'h72, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b11, 2'b00, 8'h72, 4'd2}, // R2 divide by 8
    {1'b0, 32'h0000_0000, 1'b0, 2'b00, 2'b00, 8'h72, 4'd2}, // R2 no in_en
    {1'b1, 32'h0011_0010, 1'b0, 2'b00, 2'b11, 8'h72, 4'd3}, // R3 both
    {1'b0, 32'h0000_0000, 1'b1, 2'b00, 2'b11, 8'h72, 4'd3},
    {1'b0, 32'h0000_0000, 1'b1, 2'b00, 2'b11, 8'h72, 4'd3},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b10, 8'h70, 4'd5},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b10, 8'h70, 4'd8},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b10, 8'h70, 4'd8},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b10, 8'h70, 4'd8},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b10, 8'h70, 4'd8},
    {1'b0, 32'h0000_0000, 1'b1, 2'b11, 2'b00, 8'h10, 4'd5},
    {1'b0, 32'h0000_0000, 1'b1, 2'b01, 2'b00, 8'h10, 4'd2},
    {1'b0, 32'h0000_0000, 1'b1, 2'b11, 2'b00, 8'h10, 4'd2}
  };

  task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic e,
                      input logic [1:0] p, input logic [1:0] b, input logic [7:0] r, input int req);
    @(negedge clk);
    wr_en = w; wr_data = d; in_en = e;
    #2 check("pulse", req, {6'd0, div_en_o}, {6'd0, p});
    @(posedge clk);
    #2;
    check("busy", req, {6'd0, busy_o}, {6'd0, b});
    check("ratio", req, ratio_o, r);
    wr_en = 1'b0; in_en = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("busy@reset", 1, {6'd0, busy_o}, 8'h00);
    check("ratio@reset", 1, ratio_o, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      step(v.wr, v.data, v.en, v.pulse, v.busy, v.ratio, int'(v.req));
    end
    // R6 last of several writes loads; R3 ratio held before boundary
    step(1'b1, 32'h0001_0005, 1'b0, 2'b00, 2'b01, 8'h10, 6);
    step(1'b1, 32'h0001_0003, 1'b0, 2'b00, 2'b01, 8'h10, 6);
    step(1'b1, 32'h0001_0001, 1'b0, 2'b00, 2'b01, 8'h10, 6);
    step(1'b0, 32'h0, 1'b1, 2'b01, 2'b00, 8'h11, 5);
    // R1 reset while an update is pending
    step(1'b1, 32'h0011_0044, 1'b0, 2'b00, 2'b11, 8'h11, 3);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #2;
    check("busy after reset", 1, {6'd0, busy_o}, 8'h00);
    check("ratio after reset", 1, ratio_o, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 32'h0, 1'b1, 2'b11, 2'b00, 8'h00, 1);
    step(1'b0, 32'h0, 1'b1, 2'b11, 2'b00, 8'h00, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule